// File: doc/BRIEF.md
# Loop-Aware Trap Return PC Corrector

This unit sits beside a trap handler's return path in a core that has two zero-overhead hardware loops. When an environment-call or breakpoint instruction traps, the saved return PC points at the trapping instruction. If that instruction happens to be the final body instruction of a hardware loop, simply stepping past it would leave the loop early. The unit takes the saved PC, both loop register sets and a classification of the trapping instruction. It then produces the PC that the handler should return to, together with a one-cycle strobe that tells the loop logic to decrement a loop count.

Software or a sequencer pulses `start_i` with all inputs valid. One cycle later `done_o` pulses, and the corrected PC and strobes are valid. The PC stays held until the next start. A mode input chooses whether the machine-mode saved PC or the debug-mode saved PC is corrected. The chosen mode is echoed with the result, so the caller knows which register to write back. Loop 0 is the inner loop and is always examined first. Each loop's end address is the address just past its last body instruction, and all body instructions are 4 bytes.

Top module: `loop_trap_pc_fixup`

## Requirements
- R1: If the selected PC equals end0 − 4 and count0 > 1, the result PC is start0 and `dec0_o` pulses.
- R2: If the selected PC equals end0 − 4 and count0 = 1, the result PC is PC + 4 and `dec0_o` pulses.
- R3: Only when neither R1 nor R2 applies are the same two rules applied to loop 1 (start1, end1, count1, strobe `dec1_o`). At most one of the two strobes is ever high.
- R4: If no earlier rule applies and start0 ≤ PC < end0 − 4 or start1 ≤ PC < end1 − 4 (unsigned, modulo 2^XLEN), the result PC is PC + 4 and no strobe is raised.
- R5: Otherwise, if `trap_full_i` = 1 (the trapping instruction is a 4-byte ecall or ebreak), the result PC is PC + 4 and no strobe is raised.
- R6: Otherwise, if `trap_short_i` = 1 (the trapping instruction is a 2-byte compressed ebreak), the result PC is PC + 2 and no strobe is raised.
- R7: If no rule applies, the result PC equals the selected PC and no strobe is raised.
- R8: `done_o` is high exactly in the cycle after a cycle with `start_i` high. The strobes are only high together with `done_o`. `pc_o` and `dbg_mode_o` keep their values, whatever the inputs do, until the next start.
- R9: `dbg_mode_i` = 1 selects `dpc_i` as the PC to correct and `dbg_mode_i` = 0 selects `mepc_i`. The other PC input has no effect. The selected mode appears on `dbg_mode_o` with the result.
- R10: During reset and after it, until the first start, `done_o`, `dec0_o`, `dec1_o`, `dbg_mode_o` and `pc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a correction with the current inputs |
| dbg_mode_i | input | 1 | 1: correct debug saved PC, 0: correct machine saved PC |
| mepc_i | input | XLEN | Machine-mode saved PC |
| dpc_i | input | XLEN | Debug-mode saved PC |
| lp0_start_i | input | XLEN | Loop 0 (inner) first body address |
| lp0_end_i | input | XLEN | Loop 0 address after the last body instruction |
| lp0_count_i | input | CNTW | Loop 0 remaining count |
| lp1_start_i | input | XLEN | Loop 1 (outer) first body address |
| lp1_end_i | input | XLEN | Loop 1 address after the last body instruction |
| lp1_count_i | input | CNTW | Loop 1 remaining count |
| trap_full_i | input | 1 | Trapping instruction is a 4-byte ecall/ebreak |
| trap_short_i | input | 1 | Trapping instruction is a 2-byte compressed ebreak |
| done_o | output | 1 | Result valid pulse |
| dbg_mode_o | output | 1 | Mode the result belongs to |
| pc_o | output | XLEN | Corrected return PC |
| dec0_o | output | 1 | Decrement loop 0 count |
| dec1_o | output | 1 | Decrement loop 1 count |

## Verification
Two rules can compete for the same request in several ways. When both loops share an end address, the trapping PC is the last instruction of both loops at once. A loop's last-instruction match can also coincide with a body-range hit or a set trap-kind flag. One loop configuration gives both loops the same end address, and the sweep runs every PC in the window against all count and flag combinations. In each collision the bench checks that the higher rule decides both the PC and which strobe fires. For example, loop 0 must win with `dec1_o` low when count0 ≥ 1. When count0 = 0, loop 1 must take over.

// File: rtl/loop_trap_pc_fixup.sv
module loop_trap_pc_fixup #(
  parameter int XLEN = 32,
  parameter int CNTW = 32,
  parameter int ILEN = 4,
  parameter int CLEN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            dbg_mode_i,
  input  logic [XLEN-1:0] mepc_i,
  input  logic [XLEN-1:0] dpc_i,
  input  logic [XLEN-1:0] lp0_start_i,
  input  logic [XLEN-1:0] lp0_end_i,
  input  logic [CNTW-1:0] lp0_count_i,
  input  logic [XLEN-1:0] lp1_start_i,
  input  logic [XLEN-1:0] lp1_end_i,
  input  logic [CNTW-1:0] lp1_count_i,
  input  logic            trap_full_i,
  input  logic            trap_short_i,
  output logic            done_o,
  output logic            dbg_mode_o,
  output logic [XLEN-1:0] pc_o,
  output logic            dec0_o,
  output logic            dec1_o
);

  localparam logic [XLEN-1:0] STEP_W = XLEN'(ILEN);
  localparam logic [XLEN-1:0] STEP_C = XLEN'(CLEN);
  localparam logic [CNTW-1:0] ONE    = CNTW'(1);

  logic [XLEN-1:0] pc_sel, last0, last1, pc_w, pc_c;
  logic            at0, at1, in0, in1;
  logic [XLEN-1:0] nxt_pc;
  logic            nxt_d0, nxt_d1;

  assign pc_sel = dbg_mode_i ? dpc_i : mepc_i;
  assign last0  = lp0_end_i - STEP_W;
  assign last1  = lp1_end_i - STEP_W;
  assign pc_w   = pc_sel + STEP_W;
  assign pc_c   = pc_sel + STEP_C;
  assign at0    = (pc_sel == last0) && (lp0_count_i != '0);
  assign at1    = (pc_sel == last1) && (lp1_count_i != '0);
  assign in0    = (pc_sel >= lp0_start_i) && (pc_sel < last0);
  assign in1    = (pc_sel >= lp1_start_i) && (pc_sel < last1);

  always_comb begin
    nxt_pc = pc_sel;
    nxt_d0 = 1'b0;
    nxt_d1 = 1'b0;
    if (at0) begin
      nxt_pc = (lp0_count_i > ONE) ? lp0_start_i : pc_w;
      nxt_d0 = 1'b1;
    end else if (at1) begin
      nxt_pc = (lp1_count_i > ONE) ? lp1_start_i : pc_w;
      nxt_d1 = 1'b1;
    end else if (in0 || in1) begin
      nxt_pc = pc_w;
    end else if (trap_full_i) begin
      nxt_pc = pc_w;
    end else if (trap_short_i) begin
      nxt_pc = pc_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      dec0_o     <= 1'b0;
      dec1_o     <= 1'b0;
      dbg_mode_o <= 1'b0;
      pc_o       <= '0;
    end else begin
      done_o <= start_i;
      dec0_o <= start_i && nxt_d0;
      dec1_o <= start_i && nxt_d1;
      if (start_i) begin
        pc_o       <= nxt_pc;
        dbg_mode_o <= dbg_mode_i;
      end
    end
  end

  assert_done_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> done_o);
  assert_done_has_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i));
  assert_strobe_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec0_o, dec1_o}));
  assert_strobe_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec0_o || dec1_o) |-> done_o);
  assert_result_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(pc_o) && $stable(dbg_mode_o)));
  assert_loop0_back_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pc_sel == last0 && lp0_count_i > ONE) |=> (dec0_o && pc_o == $past(lp0_start_i)));
  assert_loop0_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && pc_sel == last0 && lp0_count_i == ONE) |=> (dec0_o && pc_o == $past(pc_sel) + STEP_W));
  assert_short_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !at0 && !at1 && !in0 && !in1 && !trap_full_i && trap_short_i)
      |=> (pc_o == $past(pc_sel) + STEP_C && !dec0_o && !dec1_o));

endmodule

// File: tb/test_loop_trap_pc_fixup.sv
module test_loop_trap_pc_fixup;
  localparam int XLEN = 32;
  localparam int CNTW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0, dbg_mode_i = 1'b0;
  logic [XLEN-1:0] mepc_i = '0, dpc_i = '0;
  logic [XLEN-1:0] lp0_start_i = '0, lp0_end_i = '0, lp1_start_i = '0, lp1_end_i = '0;
  logic [CNTW-1:0] lp0_count_i = '0, lp1_count_i = '0;
  logic            trap_full_i = 1'b0, trap_short_i = 1'b0;
  logic            done_o, dbg_mode_o, dec0_o, dec1_o;
  logic [XLEN-1:0] pc_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  loop_trap_pc_fixup #(.XLEN(XLEN), .CNTW(CNTW)) i_loop_trap_pc_fixup (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbg_mode_i(dbg_mode_i),
    .mepc_i(mepc_i), .dpc_i(dpc_i),
    .lp0_start_i(lp0_start_i), .lp0_end_i(lp0_end_i), .lp0_count_i(lp0_count_i),
    .lp1_start_i(lp1_start_i), .lp1_end_i(lp1_end_i), .lp1_count_i(lp1_count_i),
    .trap_full_i(trap_full_i), .trap_short_i(trap_short_i),
    .done_o(done_o), .dbg_mode_o(dbg_mode_o), .pc_o(pc_o), .dec0_o(dec0_o), .dec1_o(dec1_o));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] pc, input logic [31:0] s0, input logic [31:0] e0, input int c0,
                       input logic [31:0] s1, input logic [31:0] e1, input int c1,
                       input bit full, input bit short,
                       output logic [31:0] epc, output bit d0, output bit d1, output string tag);
    logic [31:0] l0, l1;
    l0 = e0 - 32'd4;
    l1 = e1 - 32'd4;
    d0 = 0; d1 = 0;
    if (pc == l0 && c0 > 1)       begin epc = s0;          d0 = 1; tag = "R1"; end
    else if (pc == l0 && c0 == 1) begin epc = pc + 32'd4;  d0 = 1; tag = "R2"; end
    else if (pc == l1 && c1 > 1)  begin epc = s1;          d1 = 1; tag = "R3"; end
    else if (pc == l1 && c1 == 1) begin epc = pc + 32'd4;  d1 = 1; tag = "R3"; end
    else if ((pc >= s0 && pc < l0) || (pc >= s1 && pc < l1)) begin epc = pc + 32'd4; tag = "R4"; end
    else if (full)                begin epc = pc + 32'd4;  tag = "R5"; end
    else if (short)               begin epc = pc + 32'd2;  tag = "R6"; end
    else                          begin epc = pc;          tag = "R7"; end
  endtask

  task automatic run_one(input logic [31:0] pc, input logic [31:0] s0, input logic [31:0] e0, input int c0,
                         input logic [31:0] s1, input logic [31:0] e1, input int c1,
                         input bit full, input bit short, input bit mode);
    logic [31:0] epc;
    bit d0, d1;
    string tag;
    model(pc, s0, e0, c0, s1, e1, c1, full, short, epc, d0, d1, tag);
    dbg_mode_i = mode;
    mepc_i = mode ? (pc ^ 32'h40) : pc;
    dpc_i  = mode ? pc : (pc ^ 32'h40);
    lp0_start_i = s0; lp0_end_i = e0; lp0_count_i = CNTW'(c0);
    lp1_start_i = s1; lp1_end_i = e1; lp1_count_i = CNTW'(c1);
    trap_full_i = full; trap_short_i = short;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8", "done", 64'(done_o), 64'd1);
    chk(tag, "pc", 64'(pc_o), 64'(epc));
    chk(tag, "dec0", 64'(dec0_o), 64'(d0));
    chk(tag, "dec1", 64'(dec1_o), 64'(d1));
    chk("R9", "mode echo", 64'(dbg_mode_o), 64'(mode));
    mepc_i = ~mepc_i; dpc_i = ~dpc_i; dbg_mode_i = ~mode;
    lp0_count_i = 3; lp1_count_i = 3; trap_full_i = 1'b1;
    @(negedge clk);
    chk("R8", "done drop", 64'(done_o), 64'd0);
    chk("R8", "strobes drop", 64'({dec0_o, dec1_o}), 64'd0);
    chk("R8", "pc hold", 64'(pc_o), 64'(epc));
    chk("R8", "mode hold", 64'(dbg_mode_o), 64'(mode));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "done in reset", 64'(done_o), 64'd0);
    chk("R10", "pc in reset", 64'(pc_o), 64'd0);
    chk("R10", "strobes in reset", 64'({dec0_o, dec1_o, dbg_mode_o}), 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "pc after reset", 64'(pc_o), 64'd0);
    chk("R10", "done after reset", 64'(done_o), 64'd0);

    for (int cfg = 0; cfg < 3; cfg++) begin
      logic [31:0] s0, e0, s1, e1;
      case (cfg)
        0: begin s0 = 32'h100; e0 = 32'h10C; s1 = 32'h0F8; e1 = 32'h118; end
        1: begin s0 = 32'h0C0; e0 = 32'h0D0; s1 = 32'h110; e1 = 32'h124; end
        default: begin s0 = 32'h110; e0 = 32'h120; s1 = 32'h0E0; e1 = 32'h120; end
      endcase
      for (int p = 32'h0B8; p <= 32'h130; p += 2)
        for (int c0 = 0; c0 < 3; c0++)
          for (int c1 = 0; c1 < 3; c1++)
            for (int f = 0; f < 4; f++)
              for (int m = 0; m < 2; m++)
                run_one(32'(p), s0, e0, c0, s1, e1, c1, f[0], f[1], m[0]);
    end

    run_one(32'hFFFF_FFFC, 32'hFFFF_FFF0, 32'h0, 2, 32'h0, 32'h0, 0, 1'b0, 1'b0, 1'b0);
    run_one(32'hFFFF_FFFC, 32'hFFFF_FFF0, 32'h0, 1, 32'h0, 32'h0, 0, 1'b0, 1'b0, 1'b1);
    run_one(32'h0000_1000, 32'h100, 32'h110, 7, 32'h200, 32'h220, 9, 1'b0, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule